// File: doc/BRIEF.md
# Mirrored Video Memory Write-Policy Controller

This block is a byte-addressed video memory sitting on a simple synchronous request bus. The physical store is three address units long, while the CPU-visible window is four units long. Every incoming address is first folded into the store. Addresses in the fourth unit land on the third unit, so the top unit of the window is a mirror of the unit before it. Reads and writes may be 8, 16 or 32 bits wide. All data is little-endian.

Byte writes follow a special policy. A byte write is never stored as a single byte. Its value is copied into both bytes of the halfword that contains the addressed byte. A byte write is also discarded outright when its folded address falls in the upper region of the store. The size of that upper region depends on the 3-bit background mode input. Halfword and word writes are never filtered.

The unit size is the parameter `UNIT_AW`, where one unit is 2^UNIT_AW bytes. The full-size configuration is `UNIT_AW = 15`, which gives a 96 KiB store behind a 128 KiB window. The default `UNIT_AW = 8` gives a 768-byte store behind a 1 KiB window. All addresses below are quoted for the default. Size codes on `req_size` are: 0 = byte, 1 = halfword, 2 = word, 3 = no access.

Top module: `vram_mirror_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low on a clock edge), every store location reads as zero and `rd_valid` is low.
- R2: Only the low `UNIT_AW+2` address bits (0x3FF by default) select a location. Any higher address bits have no effect.
- R3: A masked address below three units (0x300) is used unchanged. A masked address at or above it is mapped to two units plus its low `UNIT_AW` bits (0x200 + a[7:0]), so 0x300–0x3FF alias 0x200–0x2FF.
- R4: A halfword or word write stores its data little-endian at the folded address. Address bit 0 is forced to zero for halfwords, and bits 1:0 are forced to zero for words.
- R5: An accepted byte write clears address bit 0 and stores the byte value into both bytes of that halfword. The other halfword of the word is unchanged.
- R6: In background modes 0, 1 and 2, a byte write whose folded address is at or above two units (0x200) changes nothing.
- R7: In background modes 3 to 7, a byte write whose folded address is at or above two and a half units (0x280) changes nothing. Byte writes below that address are accepted.
- R8: A read returns little-endian data from the folded, size-aligned address, zero-extended to 32 bits, on `rd_data`. `rd_valid` is high in the cycle after the read request and low in every other cycle.
- R9: Size code 3 writes nothing, and a read with size code 3 returns zero.
- R10: Halfword and word writes are stored in every background mode and at every address, including the regions where byte writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the store |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 no access |
| req_addr | input | 32 | Byte address before masking and folding |
| req_wdata | input | 32 | Write data, right-aligned for narrow sizes |
| bg_mode | input | 3 | Current background mode |
| rd_data | output | 32 | Read data, zero-extended, valid with `rd_valid` |
| rd_valid | output | 1 | High in the cycle after a read request |

## Verification
The bench aims at the fold boundary. Writes through the mirrored top unit must show up at the aliased lower address, and a design that masked to a power of two or wrapped to zero would return stale data there. Byte writes are aimed at both sides of 0x200 and 0x280 across all eight modes. An off-by-one threshold or an inverted mode test would either corrupt a protected halfword or lose a legal write. Byte writes are read back as full words, which exposes any design that writes only one lane or duplicates into the wrong halfword. Upper address garbage and size code 3 check that nothing leaks past the window mask or the size decode.

// File: rtl/vram_pkg.sv
package vram_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } vsize_e;

  // Window mask then alias the fourth unit onto the third by clearing
  // the unit bit when both top window bits are set.
  function automatic logic [31:0] fold_addr(input logic [31:0] a, input int unsigned uaw);
    logic [31:0] win_mask;
    logic [31:0] m;
    logic [31:0] top;
    win_mask = (32'd1 << (uaw + 2)) - 32'd1;
    m        = a & win_mask;
    top      = (m >> uaw) & 32'd3;
    if (top == 32'd3) return m & ~(32'd1 << uaw);
    return m;
  endfunction

  // Byte-write protection: the lower threshold applies to modes 0..2,
  // the higher one (two and a half units) to every other mode.
  function automatic logic byte_blocked(input logic [31:0] phys, input logic [2:0] mode,
                                        input int unsigned uaw);
    logic [31:0] limit;
    if (mode <= 3'd2) limit = 32'd2 << uaw;
    else              limit = (32'd2 << uaw) + (32'd1 << (uaw - 1));
    return phys >= limit;
  endfunction

  // Extract and zero-extend a read result from a stored word.
  function automatic logic [31:0] pick_read(input logic [31:0] w, input logic [1:0] off,
                                            input vsize_e sz);
    logic [31:0] sh;
    sh = w >> {off, 3'b000};
    case (sz)
      SZ_BYTE: return {24'd0, sh[7:0]};
      SZ_HALF: return {16'd0, sh[15:0]};
      SZ_WORD: return w;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/vram_addr_fold.sv
module vram_addr_fold #(
  parameter int unsigned UNIT_AW = 8,
  localparam int unsigned PA_W   = UNIT_AW + 2
) (
  input  logic [31:0]     raw_addr,
  output logic [PA_W-1:0] phys_addr
);
  import vram_pkg::*;

  logic [31:0] folded;

  always_comb begin
    folded    = fold_addr(raw_addr, UNIT_AW);
    phys_addr = folded[PA_W-1:0];
  end

endmodule

// File: rtl/vram_write_policy.sv
module vram_write_policy #(
  parameter int unsigned UNIT_AW = 8,
  localparam int unsigned PA_W   = UNIT_AW + 2,
  localparam int unsigned IDX_W  = UNIT_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic                we,
  input  vram_pkg::vsize_e    size,
  input  logic [PA_W-1:0]     phys,
  input  logic [31:0]         wdata,
  input  logic [2:0]          mode,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [3:0]          lane_en,
  output logic [31:0]         wr_word,
  output logic                byte_drop
);
  import vram_pkg::*;

  logic        wr_req;
  logic [3:0]  half_lanes;
  logic [31:0] phys32;

  assign wr_req     = valid && we;
  assign phys32     = {{(32-PA_W){1'b0}}, phys};
  assign half_lanes = phys[1] ? 4'b1100 : 4'b0011;
  assign wr_idx     = phys[PA_W-1:2];

  always_comb begin
    byte_drop = wr_req && (size == SZ_BYTE) && byte_blocked(phys32, mode, UNIT_AW);
    lane_en   = 4'b0000;
    wr_word   = wdata;
    case (size)
      SZ_BYTE: begin
        lane_en = half_lanes;
        wr_word = {4{wdata[7:0]}};
      end
      SZ_HALF: begin
        lane_en = half_lanes;
        wr_word = {2{wdata[15:0]}};
      end
      SZ_WORD: lane_en = 4'b1111;
      default: lane_en = 4'b0000;
    endcase
    wr_en = wr_req && (size != SZ_NONE) && !byte_drop;
  end

  // R5: a stored byte occupies exactly one halfword, both bytes equal
  a_r5_byte_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == SZ_BYTE) |->
      ((lane_en == 4'b0011 || lane_en == 4'b1100) && wr_word[7:0] == wr_word[15:8]));

  // R10: wide writes always reach the store
  a_r10_wide_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (size == SZ_HALF || size == SZ_WORD)) |-> wr_en);

  // R4: word writes drive all four lanes
  a_r4_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == SZ_WORD) |-> (lane_en == 4'b1111));

  // R9: size code 3 never writes
  a_r9_none_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (size == SZ_NONE) |-> !wr_en);

endmodule

// File: rtl/vram_store.sv
module vram_store #(
  parameter int unsigned UNIT_AW = 8,
  localparam int unsigned IDX_W  = UNIT_AW,
  localparam int unsigned WORDS  = (3 * (1 << UNIT_AW)) / 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [3:0]       lane_en,
  input  logic [31:0]      wr_word,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_off,
  input  vram_pkg::vsize_e rd_size,
  output logic [31:0]      rd_data,
  output logic             rd_valid
);
  import vram_pkg::*;

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < int'(WORDS); w++) mem[w] <= 32'd0;
    end else if (wr_en) begin
      for (int l = 0; l < 4; l++)
        if (lane_en[l]) mem[wr_idx][8*l +: 8] <= wr_word[8*l +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= 32'd0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= pick_read(mem[rd_idx], rd_off, rd_size);
    end
  end

  // R3: folding never points outside the physical store
  a_r3_idx_in_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |-> (32'(wr_idx) < WORDS && 32'(rd_idx) < WORDS));

  // R8: read data appears exactly one cycle after the request
  a_r8_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

endmodule

// File: rtl/vram_mirror_ctrl.sv
module vram_mirror_ctrl #(
  parameter int unsigned UNIT_AW = 8,
  localparam int unsigned PA_W   = UNIT_AW + 2,
  localparam int unsigned IDX_W  = UNIT_AW
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [2:0]  bg_mode,
  output logic [31:0] rd_data,
  output logic        rd_valid
);
  import vram_pkg::*;

  vsize_e           size;
  logic [PA_W-1:0]  phys;
  logic [PA_W-1:0]  phys_aligned;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [3:0]       lane_en;
  logic [31:0]      wr_word;
  logic             byte_drop;
  logic             rd_en;

  assign size = vsize_e'(req_size);

  vram_addr_fold #(.UNIT_AW(UNIT_AW)) u_fold (
    .raw_addr  (req_addr),
    .phys_addr (phys)
  );

  // Natural alignment for the read path (write path aligns by lanes)
  always_comb begin
    phys_aligned = phys;
    if (size == SZ_HALF) phys_aligned[0]   = 1'b0;
    if (size == SZ_WORD) phys_aligned[1:0] = 2'b00;
  end

  assign rd_en = req_valid && !req_we;

  vram_write_policy #(.UNIT_AW(UNIT_AW)) u_policy (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (req_valid),
    .we        (req_we),
    .size      (size),
    .phys      (phys),
    .wdata     (req_wdata),
    .mode      (bg_mode),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .lane_en   (lane_en),
    .wr_word   (wr_word),
    .byte_drop (byte_drop)
  );

  vram_store #(.UNIT_AW(UNIT_AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .lane_en  (lane_en),
    .wr_word  (wr_word),
    .rd_en    (rd_en),
    .rd_idx   (phys_aligned[PA_W-1:2]),
    .rd_off   (phys_aligned[1:0]),
    .rd_size  (size),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R6 / R7: a dropped byte write must not reach the store
  a_r6_r7_drop_gates_store: assert property (@(posedge clk) disable iff (!rst_n)
    byte_drop |-> !wr_en);

  // R6: in modes 0..2 any byte write in the upper third is dropped
  a_r6_low_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && size == SZ_BYTE && bg_mode <= 3'd2 && phys[PA_W-1]) |-> byte_drop);

  // R1: no read result in the cycle after reset is released without a request
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !rd_valid);

endmodule

// File: tb/sim_vram_mirror_ctrl.sv
module sim_vram_mirror_ctrl;

  localparam int unsigned UAW   = 8;
  localparam int unsigned UNIT  = 1 << UAW;
  localparam int unsigned WIN   = 4 * UNIT;
  localparam int unsigned STORE = 3 * UNIT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = 32'd0;
  logic [31:0] req_wdata = 32'd0;
  logic [2:0]  bg_mode = 3'd0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [7:0] model [STORE];

  always #2 clk = ~clk;

  vram_mirror_ctrl #(.UNIT_AW(UAW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .bg_mode(bg_mode), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Folding restated as modulo and subtraction
  function automatic int unsigned bfold(input logic [31:0] a);
    int unsigned m;
    m = a % WIN;
    return (m >= STORE) ? m - UNIT : m;
  endfunction

  function automatic bit bdrop(input logic [31:0] a, input logic [2:0] mode);
    int unsigned f;
    f = bfold(a);
    if (mode < 3) return f >= 2 * UNIT;
    return f >= 2 * UNIT + UNIT / 2;
  endfunction

  function automatic logic [31:0] bexpect(input logic [1:0] sz, input logic [31:0] a);
    int unsigned f;
    f = bfold(a);
    case (sz)
      2'd0: return {24'd0, model[f]};
      2'd1: return {16'd0, model[f - f % 2 + 1], model[f - f % 2]};
      2'd2: return {model[f - f % 4 + 3], model[f - f % 4 + 2],
                    model[f - f % 4 + 1], model[f - f % 4]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic void bwrite(input logic [1:0] sz, input logic [31:0] a,
                                 input logic [31:0] d, input logic [2:0] mode);
    int unsigned f;
    f = bfold(a);
    case (sz)
      2'd0: if (!bdrop(a, mode)) begin
        model[f - f % 2] = d[7:0];
        model[f - f % 2 + 1] = d[7:0];
      end
      2'd1: begin
        model[f - f % 2] = d[7:0];
        model[f - f % 2 + 1] = d[15:8];
      end
      2'd2: for (int k = 0; k < 4; k++) model[f - f % 4 + k] = d[8*k +: 8];
      default: ;
    endcase
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] d, input logic [2:0] mode);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_size = sz; req_addr = a;
    req_wdata = d; bg_mode = mode;
    bwrite(sz, a, d, mode);
    @(negedge clk);
    req_valid = 1'b0;
    check({31'd0, rd_valid}, 32'd0, "R8 valid low after write");
  endtask

  task automatic do_read(input logic [1:0] sz, input logic [31:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_size = sz; req_addr = a;
    bg_mode = 3'($urandom_range(0, 7));
    @(negedge clk);
    req_valid = 1'b0;
    check({31'd0, rd_valid}, 32'd1, "R8 valid after read");
    check(rd_data, bexpect(sz, a), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < int'(STORE); i++) model[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({31'd0, rd_valid}, 32'd0, "R1 valid low after reset");
    do_read(2'd2, 32'h0000_0000, "R1 zero at reset");
    do_read(2'd2, 32'h0000_02FC, "R1 zero at reset");

    // R2: upper bits ignored
    do_write(2'd2, 32'hABCD_0010, 32'h1122_3344, 3'd0);
    do_read(2'd2, 32'h0000_0010, "R2 upper bits masked");
    do_read(2'd1, 32'h0000_0012, "R4 halfword little-endian");
    do_read(2'd2, 32'h0000_0013, "R4 word alignment forced");

    // R3: mirror bank both directions
    do_write(2'd2, 32'h0000_02F0, 32'hCAFE_F00D, 3'd0);
    do_read(2'd2, 32'h0000_03F0, "R3 mirror read");
    do_write(2'd1, 32'h0000_03F5, 32'h0000_BEEF, 3'd0);
    do_read(2'd2, 32'h0000_02F4, "R3 mirror write");

    // R5: byte replication
    do_write(2'd0, 32'h0000_0041, 32'h0000_005A, 3'd3);
    do_read(2'd2, 32'h0000_0040, "R5 byte fills low halfword");
    do_write(2'd0, 32'h0000_0042, 32'h0000_00C3, 3'd0);
    do_read(2'd2, 32'h0000_0040, "R5 byte fills high halfword");
    do_read(2'd0, 32'h0000_0041, "R8 byte read");

    // R6 / R7 / R10: drop thresholds
    do_write(2'd2, 32'h0000_0210, 32'h0102_0304, 3'd1);
    do_read(2'd2, 32'h0000_0210, "R10 word kept in protected region");
    do_write(2'd0, 32'h0000_0210, 32'h0000_00EE, 3'd1);
    do_read(2'd2, 32'h0000_0210, "R6 byte dropped mode 1");
    do_write(2'd0, 32'h0000_01FF, 32'h0000_0077, 3'd2);
    do_read(2'd2, 32'h0000_01FC, "R6 byte kept below threshold");
    do_write(2'd0, 32'h0000_0210, 32'h0000_0099, 3'd5);
    do_read(2'd2, 32'h0000_0210, "R7 byte kept mode 5");
    do_write(2'd1, 32'h0000_0290, 32'h0000_1234, 3'd0);
    do_write(2'd0, 32'h0000_0290, 32'h0000_0055, 3'd5);
    do_read(2'd2, 32'h0000_0290, "R7 byte dropped mode 5");
    do_write(2'd0, 32'h0000_0390, 32'h0000_0066, 3'd7);
    do_read(2'd2, 32'h0000_0290, "R7 mirrored byte dropped");
    do_write(2'd0, 32'h0000_027F, 32'h0000_0044, 3'd4);
    do_read(2'd2, 32'h0000_027C, "R7 byte kept just below threshold");

    // R9: size code 3
    do_write(2'd3, 32'h0000_0060, 32'hFFFF_FFFF, 3'd0);
    do_read(2'd2, 32'h0000_0060, "R9 no write");
    do_read(2'd3, 32'h0000_0010, "R9 read zero");

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0]  sz;
      logic [31:0] a;
      sz = 2'($urandom_range(0, 3));
      a  = $urandom();
      if ($urandom_range(0, 1) == 1) a = {22'($urandom()), 10'($urandom_range(512, 1023))};
      if ($urandom_range(0, 2) != 0)
        do_write(sz, a, $urandom(), 3'($urandom_range(0, 7)));
      else
        do_read(sz, a, "R8 random read");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule